// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power mode a small processor subsystem is in. Software enters a mode by writing a 3-bit code to the mode register. It leaves the low-power modes only when a qualifying wake-up event arrives. The block drives four things: the core clock enable, the peripheral standby request, the display refresh enable, and the ring-oscillator select. It also raises a one-cycle reset request on exit from the two sleep modes and a power-off request in deep sleep. A status field reports the current mode and the cause of the last wake-up.

Wake qualification depends on the mode. In core idle, any pending interrupt wakes the core. The interrupt mask takes part only when the obey-mask control bit is set. In the two standby modes and in both sleep modes, only pin wake-up events count. Clock generation, regulators and the interrupt controller are outside the block and appear only as inputs and outputs.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the block is in run mode (code 0). The wake cause is 0 (none), `reset_req` is low and `core_clk_en` is high.
- R2: A write of code 5, the only unused code, is ignored and the mode does not change.
- R3: From run or ring-oscillator run, a write of a valid code (0, 1, 2, 3, 4, 6, 7) takes effect on the next clock edge. Code 1 (core idle) drops `core_clk_en` and keeps `disp_refresh_en` high and `periph_stby` low.
- R4: In core idle with `obey_mask` low, any bit of `irq_pend` returns the block to run on the next edge, even if its `irq_mask` bit is 0. The wake cause becomes 1 (interrupt).
- R5: In core idle with `obey_mask` high, only a pending bit whose `irq_mask` bit is 1 (1 = enabled) wakes the core. Masked pending bits leave the mode unchanged.
- R6: Code 4 (ring-oscillator run) raises `ring_osc_sel` and keeps `core_clk_en` high. Interrupts and pin events have no effect in this mode, and it is left by a software write.
- R7: In standby (code 3) and in standby with display (code 2), any `pin_wake` bit returns the block to run with cause 2 (pin), and interrupts have no effect. `periph_stby` is high in both modes, and `disp_refresh_en` is high only in code 2.
- R8: A pin event in sleep (code 6) or deep sleep (code 7) returns the block to mode 0 with `reset_req` high for exactly one cycle, during which `core_clk_en` stays low. `deep_off` is high only in code 7.
- R9: In every low-power mode (codes 1, 2, 3, 6, 7), `core_clk_en` is low and mode-register writes are ignored.
- R10: A wake event that qualifies for the new mode and is present in the same cycle as the mode write is kept. The block enters the mode and exits on the following edge, even if the event has gone by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_code | input | 3 | Mode code to write |
| irq_pend | input | NSRC | Per-source interrupt pending lines |
| irq_mask | input | NSRC | Interrupt mask, 1 = enabled |
| obey_mask | input | 1 | Make idle wake-up honour the mask |
| pin_wake | input | NPIN | Per-pin wake-up events |
| core_clk_en | output | 1 | Core clock enable |
| periph_stby | output | 1 | Peripheral standby request |
| disp_refresh_en | output | 1 | Display refresh enable |
| ring_osc_sel | output | 1 | Select ring oscillator for run |
| reset_req | output | 1 | Reset request on exit from sleep modes |
| deep_off | output | 1 | Power-off request in deep sleep |
| status_mode | output | 3 | Current mode code |
| status_cause | output | 2 | Last wake cause: 0 none, 1 interrupt, 2 pin |

## Verification
In core idle, interrupts are raised under three conditions: with the mask clear and obey-mask low, then with obey-mask high, then with the mask bit set. This separates mask-ignoring wake-up from masked wake-up. The same stimuli (pins and interrupts) are applied in ring-oscillator run, in the two standby modes and in sleep. This shows which event class each mode accepts and which exits go through a reset request. Wake events that coincide with the mode write, and then vanish, show whether such an event is kept. Writes of the unused code and writes made while in a low-power mode confirm that the register holds its value.

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
  parameter int NSRC = 8,
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_wr,
  input  logic [2:0]      mode_code,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_mask,
  input  logic            obey_mask,
  input  logic [NPIN-1:0] pin_wake,
  output logic            core_clk_en,
  output logic            periph_stby,
  output logic            disp_refresh_en,
  output logic            ring_osc_sel,
  output logic            reset_req,
  output logic            deep_off,
  output logic [2:0]      status_mode,
  output logic [1:0]      status_cause
);
  localparam logic [2:0] M_RUN = 3'd0, M_IDLE = 3'd1, M_SBD = 3'd2, M_SBY = 3'd3,
                         M_RING = 3'd4, M_SLP = 3'd6, M_DSL = 3'd7;
  localparam logic [1:0] C_NONE = 2'd0, C_IRQ = 2'd1, C_PIN = 2'd2;

  logic [2:0] mode_q;
  logic [1:0] cause_q, early_q;
  logic       rreq_q;

  wire irq_any = obey_mask ? |(irq_pend & irq_mask) : |irq_pend;
  wire pin_any = |pin_wake;

  function automatic logic [1:0] cause_for(input logic [2:0] m, input logic irq, input logic pin);
    if (m == M_IDLE && irq) return C_IRQ;
    if ((m == M_SBD || m == M_SBY || m == M_SLP || m == M_DSL) && pin) return C_PIN;
    return C_NONE;
  endfunction

  wire       in_lp      = (mode_q != M_RUN) && (mode_q != M_RING);
  wire       code_ok    = (mode_code != 3'd5);
  wire       wr_ok      = mode_wr && code_ok && !in_lp;
  wire [1:0] live_cause = cause_for(mode_q, irq_any, pin_any);
  wire [1:0] eff_cause  = (live_cause != C_NONE) ? live_cause : early_q;
  wire       wake       = in_lp && (eff_cause != C_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_RUN;
      cause_q <= C_NONE;
      early_q <= C_NONE;
      rreq_q  <= 1'b0;
    end else if (wake) begin
      mode_q  <= M_RUN;
      cause_q <= eff_cause;
      early_q <= C_NONE;
      rreq_q  <= (mode_q == M_SLP) || (mode_q == M_DSL);
    end else if (wr_ok) begin
      mode_q  <= mode_code;
      early_q <= cause_for(mode_code, irq_any, pin_any);
      rreq_q  <= 1'b0;
    end else begin
      early_q <= C_NONE;
      rreq_q  <= 1'b0;
    end
  end

  assign core_clk_en     = !in_lp && !rreq_q;
  assign periph_stby     = (mode_q == M_SBD) || (mode_q == M_SBY) || (mode_q == M_SLP) || (mode_q == M_DSL);
  assign disp_refresh_en = (mode_q == M_RUN) || (mode_q == M_RING) || (mode_q == M_IDLE) || (mode_q == M_SBD);
  assign ring_osc_sel    = (mode_q == M_RING);
  assign reset_req       = rreq_q;
  assign deep_off        = (mode_q == M_DSL);
  assign status_mode     = mode_q;
  assign status_cause    = cause_q;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
  parameter int NSRC = 8,
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_wr,
  input logic [2:0]      mode_code,
  input logic [NSRC-1:0] irq_pend,
  input logic            obey_mask,
  input logic [NPIN-1:0] pin_wake,
  input logic            core_clk_en,
  input logic            reset_req,
  input logic [2:0]      status_mode
);
  wire in_lp = (status_mode != 3'd0) && (status_mode != 3'd4);

  a_r2_bad_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_code == 3'd5 && !in_lp) |=> $stable(status_mode));

  a_r4_idle_ignores_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode == 3'd1 && !obey_mask && |irq_pend) |=> (status_mode == 3'd0));

  a_r7_pin_leaves_standby: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_mode == 3'd2 || status_mode == 3'd3) && |pin_wake) |=> (status_mode == 3'd0 && !reset_req));

  a_r8_sleep_exit_resets: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_mode == 3'd6 || status_mode == 3'd7) && |pin_wake) |=> (reset_req && !core_clk_en));

  a_r8_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r9_core_gated: assert property (@(posedge clk) disable iff (!rst_n)
    in_lp |-> !core_clk_en);

  a_r9_sleep_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (status_mode == 3'd6 && $stable(status_mode) && mode_wr && !(|pin_wake)) |=> (status_mode == 3'd6));
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.NSRC(NSRC), .NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
  .irq_pend(irq_pend), .obey_mask(obey_mask), .pin_wake(pin_wake),
  .core_clk_en(core_clk_en), .reset_req(reset_req), .status_mode(status_mode)
);

// File: tb/lpm_sequencer_tb_top.sv
module lpm_sequencer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0, obey_mask = 1'b0;
  logic [2:0] mode_code = 3'd0;
  logic [7:0] irq_pend = '0, irq_mask = '0;
  logic [3:0] pin_wake = '0;
  logic core_clk_en, periph_stby, disp_refresh_en, ring_osc_sel, reset_req, deep_off;
  logic [2:0] status_mode;
  logic [1:0] status_cause;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [10:0] vec; string req; } exp_t;
  exp_t q[$];
  event chk_ev;

  always #2 clk = ~clk;

  lpm_sequencer #(.NSRC(8), .NPIN(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .irq_pend(irq_pend), .irq_mask(irq_mask), .obey_mask(obey_mask), .pin_wake(pin_wake),
    .core_clk_en(core_clk_en), .periph_stby(periph_stby), .disp_refresh_en(disp_refresh_en),
    .ring_osc_sel(ring_osc_sel), .reset_req(reset_req), .deep_off(deep_off),
    .status_mode(status_mode), .status_cause(status_cause)
  );

  function automatic logic [10:0] expect_vec(input logic [2:0] m, input logic [1:0] c, input logic rr);
    logic core, stby, disp, ring, deep;
    core = (m == 3'd0 || m == 3'd4) && !rr;
    stby = (m == 3'd2 || m == 3'd3 || m == 3'd6 || m == 3'd7);
    disp = (m == 3'd0 || m == 3'd1 || m == 3'd2 || m == 3'd4);
    ring = (m == 3'd4);
    deep = (m == 3'd7);
    return {m, c, core, stby, disp, ring, rr, deep};
  endfunction

  task automatic step(input logic [2:0] m, input logic [1:0] c, input logic rr, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    e.vec = expect_vec(m, c, rr);
    e.req = req;
    q.push_back(e);
    ->chk_ev;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic [10:0] act;
        e = q.pop_front();
        act = {status_mode, status_cause, core_clk_en, periph_stby, disp_refresh_en,
               ring_osc_sel, reset_req, deep_off};
        n_run++;
        if (act !== e.vec) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", e.req, act, e.vec);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3'd0, 2'd0, 1'b0, "R1");
    step(3'd0, 2'd0, 1'b0, "R1");
    rst_n = 1'b1;
    step(3'd0, 2'd0, 1'b0, "R1");

    mode_wr = 1; mode_code = 3'd1;
    step(3'd1, 2'd0, 1'b0, "R3");
    mode_wr = 0; irq_pend = 8'h04;
    step(3'd0, 2'd1, 1'b0, "R4");
    irq_pend = 0;

    obey_mask = 1; mode_wr = 1; mode_code = 3'd1;
    step(3'd1, 2'd1, 1'b0, "R5");
    mode_wr = 0; irq_pend = 8'h04; irq_mask = 8'h00;
    step(3'd1, 2'd1, 1'b0, "R5");
    irq_mask = 8'hFB;
    step(3'd1, 2'd1, 1'b0, "R5");
    irq_mask = 8'h04;
    step(3'd0, 2'd1, 1'b0, "R5");
    irq_pend = 0; irq_mask = 0; obey_mask = 0;

    mode_wr = 1; mode_code = 3'd5;
    step(3'd0, 2'd1, 1'b0, "R2");
    mode_code = 3'd4;
    step(3'd4, 2'd1, 1'b0, "R6");
    mode_wr = 0; pin_wake = 4'hF; irq_pend = 8'hFF;
    step(3'd4, 2'd1, 1'b0, "R6");
    pin_wake = 0; irq_pend = 0; mode_wr = 1; mode_code = 3'd5;
    step(3'd4, 2'd1, 1'b0, "R2");
    mode_code = 3'd0;
    step(3'd0, 2'd1, 1'b0, "R6");

    mode_code = 3'd3;
    step(3'd3, 2'd1, 1'b0, "R7");
    mode_wr = 0; irq_pend = 8'h01; irq_mask = 8'hFF;
    step(3'd3, 2'd1, 1'b0, "R7");
    irq_pend = 0; irq_mask = 0; pin_wake = 4'h2;
    step(3'd0, 2'd2, 1'b0, "R7");
    pin_wake = 0;

    mode_wr = 1; mode_code = 3'd2;
    step(3'd2, 2'd2, 1'b0, "R7");
    mode_wr = 0; irq_pend = 8'h80;
    step(3'd2, 2'd2, 1'b0, "R7");
    irq_pend = 0; obey_mask = 1; irq_mask = 8'h01; irq_pend = 8'h01;
    mode_code = 3'd1;
    step(3'd2, 2'd2, 1'b0, "R7");
    irq_pend = 0; irq_mask = 0; obey_mask = 0; pin_wake = 4'h8;
    step(3'd0, 2'd2, 1'b0, "R7");
    pin_wake = 0;

    mode_wr = 1; mode_code = 3'd6;
    step(3'd6, 2'd2, 1'b0, "R3");
    mode_code = 3'd0;
    step(3'd6, 2'd2, 1'b0, "R9");
    mode_code = 3'd4;
    step(3'd6, 2'd2, 1'b0, "R9");
    mode_wr = 0; pin_wake = 4'h4;
    step(3'd0, 2'd2, 1'b1, "R8");
    pin_wake = 0;
    step(3'd0, 2'd2, 1'b0, "R8");

    mode_wr = 1; mode_code = 3'd7; pin_wake = 4'h1;
    step(3'd7, 2'd2, 1'b0, "R10");
    mode_wr = 0; pin_wake = 0;
    step(3'd0, 2'd2, 1'b1, "R10");
    step(3'd0, 2'd2, 1'b0, "R8");

    mode_wr = 1; mode_code = 3'd1; irq_pend = 8'h10;
    step(3'd1, 2'd2, 1'b0, "R10");
    mode_wr = 0; irq_pend = 0;
    step(3'd0, 2'd1, 1'b0, "R10");

    mode_wr = 1; mode_code = 3'd1; obey_mask = 1; irq_pend = 8'h10; irq_mask = 8'h00;
    step(3'd1, 2'd1, 1'b0, "R5");
    mode_wr = 0; irq_pend = 0;
    step(3'd1, 2'd1, 1'b0, "R5");
    mode_wr = 1; mode_code = 3'd0;
    step(3'd1, 2'd1, 1'b0, "R9");
    mode_wr = 0; obey_mask = 0; irq_pend = 8'h20;
    step(3'd0, 2'd1, 1'b0, "R4");
    irq_pend = 0;

    mode_wr = 1; mode_code = 3'd7;
    step(3'd7, 2'd1, 1'b0, "R8");
    mode_wr = 0; irq_pend = 8'hFF; irq_mask = 8'hFF;
    step(3'd7, 2'd1, 1'b0, "R8");
    irq_pend = 0; irq_mask = 0; pin_wake = 4'h2;
    step(3'd0, 2'd2, 1'b1, "R8");
    pin_wake = 0;
    step(3'd0, 2'd2, 1'b0, "R8");

    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule